// File: doc/BRIEF.md
# Register-RAM Block Transfer Engine

This engine copies a run of bytes between a small register RAM (64 bytes, addressed at half resolution by an 8-bit pointer) and an external data memory. A single start pulse supplies the direction, the starting pointer, the starting memory index and a byte count. The engine then walks through the bytes one at a time, using a request/acknowledge memory port and a combinational-read, clocked-write register RAM port. Both memories belong to the surrounding core.

After every byte, three things change. The pointer moves by two, the low eight bits of the memory index move by one while the bank bits above them stay fixed, and the count drops by one. The count is tested only after a byte has moved, so a starting count of zero runs a full 256 bytes. When the last byte is done the engine drops busy and pulses done. The final pointer, index and count stay on output ports so the core can take them back into its own registers.

Top module: `rbx_engine`

## Requirements
- R1: Out of reset the engine is idle: busy, done, memReq and regWe are all 0.
- R2: Each byte uses register RAM address ptr[6:1], which is (ptr>>1) & 0x3F. After each byte the pointer grows by 2 modulo 256, so odd pointers share the address of the even pointer below them.
- R3: Each byte uses memory address idx. After each byte idx[7:0] grows by 1 modulo 256 and idx[9:8] stays unchanged.
- R4: After each byte the count drops by 1, and the run ends once it reaches 0. A starting count of 0 moves exactly 256 bytes.
- R5: With dirToMem=1, register RAM bytes are written to memory with memWe=1. With dirToMem=0, memory bytes are read with memWe=0 and stored into register RAM.
- R6: When reading from memory, the register RAM write (regWe=1) happens in the cycle after the acknowledged read, and memReq is 0 in that cycle.
- R7: busy is 1 from the cycle after an accepted start until the last byte completes. With an acknowledge latency of d cycles, each byte takes d+2 cycles. done is 1 for exactly one cycle, the first cycle in which busy is 0 again.
- R8: A start pulse while busy is 1 is ignored. It changes neither the transfer in progress nor its results, and it starts no further run.
- R9: From done onward, finPtr, finIdx and finCnt hold the values after the last byte, and finCnt is 0.
- R10: Once memReq is raised, it stays 1 with memAddr, memWe and memWdata unchanged until the cycle in which memAck is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start pulse, accepted only when idle |
| dirToMem | input | 1 | 1: register RAM to memory; 0: memory to register RAM |
| startPtr | input | 8 | Initial register pointer |
| startIdx | input | 10 | Initial memory index (bank bits 9:8, low byte 7:0) |
| startCnt | input | 8 | Initial byte count (0 means 256) |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| memReq | output | 1 | Memory request, held until acknowledged |
| memWe | output | 1 | Memory write (1) or read (0) |
| memAddr | output | 10 | Memory address |
| memWdata | output | 8 | Memory write data |
| memAck | input | 1 | Memory acknowledge; read data valid with it |
| memRdata | input | 8 | Memory read data |
| regAddr | output | 6 | Register RAM address |
| regWe | output | 1 | Register RAM write strobe |
| regWdata | output | 8 | Register RAM write data |
| regRdata | input | 8 | Register RAM read data (combinational) |
| finPtr | output | 8 | Current/final pointer |
| finIdx | output | 10 | Current/final memory index |
| finCnt | output | 8 | Current/final count |

## Verification
Runs in both directions are compared byte for byte against a model of both memories, and the final port values are checked as well. The patterns are chosen so each one isolates a different rule:
- A mid-range run shows the basic copy and step sizes.
- A run whose index crosses 0xFF shows that the bank bits are kept on wrap.
- An odd pointer near 0xFF shows both the half-resolution addressing and the pointer wrap.
- A zero count separates the test-after-step rule from a test-before-step rule (256 bytes against none), and it revisits each register location four times.
- Different acknowledge latencies check the per-byte cycle cost and the hold of requests.
- A start pulse injected mid-run shows that it is ignored.

// File: rtl/rbx_pkg.sv
package rbx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_MWRITE,
    ST_MREAD,
    ST_STORE
  } xferState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic load;     // latch start values
    logic capRf;    // capture register RAM byte
    logic capMem;   // capture memory read byte
    logic advance;  // step pointer, index and count
  } dpStrobe_t;

endpackage

// File: rtl/rbx_ctrl.sv
module rbx_ctrl
  import rbx_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       dirToMem,
  input  logic       memAck,
  input  logic       lastByte,
  output dpStrobe_t  stb,
  output logic       busy,
  output logic       done,
  output logic       memReq,
  output logic       memWe,
  output logic       regWe
);

  xferState_t stateQ, stateD;
  logic       doneQ;
  logic       finish;

  always_comb begin
    stateD = stateQ;
    stb    = '0;
    finish = 1'b0;
    unique case (stateQ)
      ST_IDLE: begin
        if (start) begin
          stb.load = 1'b1;
          stateD   = dirToMem ? ST_FETCH : ST_MREAD;
        end
      end
      ST_FETCH: begin
        stb.capRf = 1'b1;
        stateD    = ST_MWRITE;
      end
      ST_MWRITE: begin
        if (memAck) begin
          stb.advance = 1'b1;
          if (lastByte) begin
            finish = 1'b1;
            stateD = ST_IDLE;
          end else begin
            stateD = ST_FETCH;
          end
        end
      end
      ST_MREAD: begin
        if (memAck) begin
          stb.capMem = 1'b1;
          stateD     = ST_STORE;
        end
      end
      ST_STORE: begin
        stb.advance = 1'b1;
        if (lastByte) begin
          finish = 1'b1;
          stateD = ST_IDLE;
        end else begin
          stateD = ST_MREAD;
        end
      end
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      doneQ  <= 1'b0;
    end else begin
      stateQ <= stateD;
      doneQ  <= finish;
    end
  end

  assign busy   = (stateQ != ST_IDLE);
  assign done   = doneQ;
  assign memReq = (stateQ == ST_MWRITE) || (stateQ == ST_MREAD);
  assign memWe  = (stateQ == ST_MWRITE);
  assign regWe  = (stateQ == ST_STORE);

  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  p_done_idle_r7: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);
  p_store_after_ack_r6: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memWe && memAck) |=> regWe);
  p_store_no_req_r6: assert property (@(posedge clk) disable iff (!rstN)
    regWe |-> !memReq);
  p_no_load_busy_r8: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !stb.load);
  p_req_wait_r10: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memAck) |=> (memReq && $stable(memWe)));

endmodule

// File: rtl/rbx_dp.sv
module rbx_dp
  import rbx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int PTR_W  = 8,
  parameter int IDX_W  = 8,
  parameter int ADDR_W = 10,
  parameter int CNT_W  = 8,
  parameter int RF_AW  = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         stb,
  input  logic [PTR_W-1:0]  startPtr,
  input  logic [ADDR_W-1:0] startIdx,
  input  logic [CNT_W-1:0]  startCnt,
  input  logic [DATA_W-1:0] regRdata,
  input  logic [DATA_W-1:0] memRdata,
  output logic              lastByte,
  output logic [RF_AW-1:0]  regAddr,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] dataOut,
  output logic [PTR_W-1:0]  ptrOut,
  output logic [CNT_W-1:0]  cntOut
);

  localparam int PTR_STEP = 2;

  logic [PTR_W-1:0]  ptrQ;
  logic [ADDR_W-1:0] idxQ, idxNext;
  logic [CNT_W-1:0]  cntQ;
  logic [DATA_W-1:0] dataQ;

  // Index step: low byte wraps, bank bits above it are held
  generate
    if (ADDR_W > IDX_W) begin : g_bank
      assign idxNext = {idxQ[ADDR_W-1:IDX_W], IDX_W'(idxQ[IDX_W-1:0] + 1'b1)};
    end else begin : g_flat
      assign idxNext = IDX_W'(idxQ[IDX_W-1:0] + 1'b1);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ptrQ  <= '0;
      idxQ  <= '0;
      cntQ  <= '0;
      dataQ <= '0;
    end else begin
      if (stb.load) begin
        ptrQ <= startPtr;
        idxQ <= startIdx;
        cntQ <= startCnt;
      end else if (stb.advance) begin
        ptrQ <= PTR_W'(ptrQ + PTR_W'(PTR_STEP));
        idxQ <= idxNext;
        cntQ <= CNT_W'(cntQ - 1'b1);
      end
      if (stb.capRf) begin
        dataQ <= regRdata;
      end else if (stb.capMem) begin
        dataQ <= memRdata;
      end
    end
  end

  // Count tested after the step: only a count of one ends the run
  assign lastByte = (cntQ == CNT_W'(1));
  assign regAddr  = ptrQ[RF_AW:1];
  assign memAddr  = idxQ;
  assign dataOut  = dataQ;
  assign ptrOut   = ptrQ;
  assign cntOut   = cntQ;

  p_ptr_step_r2: assert property (@(posedge clk) disable iff (!rstN)
    stb.advance |=> (ptrQ == PTR_W'($past(ptrQ) + 2)));
  p_idx_step_r3: assert property (@(posedge clk) disable iff (!rstN)
    stb.advance |=> (idxQ[IDX_W-1:0] == IDX_W'($past(idxQ[IDX_W-1:0]) + 1)));
  p_cnt_step_r4: assert property (@(posedge clk) disable iff (!rstN)
    stb.advance |=> (cntQ == CNT_W'($past(cntQ) - 1)));

  generate
    if (ADDR_W > IDX_W) begin : g_bank_chk
      p_bank_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
        stb.advance |=> $stable(idxQ[ADDR_W-1:IDX_W]));
    end
  endgenerate

endmodule

// File: rtl/rbx_engine.sv
module rbx_engine
  import rbx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int PTR_W  = 8,
  parameter int IDX_W  = 8,
  parameter int ADDR_W = 10,
  parameter int CNT_W  = 8,
  parameter int RF_AW  = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              dirToMem,
  input  logic [PTR_W-1:0]  startPtr,
  input  logic [ADDR_W-1:0] startIdx,
  input  logic [CNT_W-1:0]  startCnt,
  output logic              busy,
  output logic              done,
  output logic              memReq,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  input  logic              memAck,
  input  logic [DATA_W-1:0] memRdata,
  output logic [RF_AW-1:0]  regAddr,
  output logic              regWe,
  output logic [DATA_W-1:0] regWdata,
  input  logic [DATA_W-1:0] regRdata,
  output logic [PTR_W-1:0]  finPtr,
  output logic [ADDR_W-1:0] finIdx,
  output logic [CNT_W-1:0]  finCnt
);

  dpStrobe_t         stb;
  logic              lastByte;
  logic [DATA_W-1:0] dataOut;

  rbx_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .start    (start),
    .dirToMem (dirToMem),
    .memAck   (memAck),
    .lastByte (lastByte),
    .stb      (stb),
    .busy     (busy),
    .done     (done),
    .memReq   (memReq),
    .memWe    (memWe),
    .regWe    (regWe)
  );

  rbx_dp #(
    .DATA_W (DATA_W),
    .PTR_W  (PTR_W),
    .IDX_W  (IDX_W),
    .ADDR_W (ADDR_W),
    .CNT_W  (CNT_W),
    .RF_AW  (RF_AW)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .startPtr (startPtr),
    .startIdx (startIdx),
    .startCnt (startCnt),
    .regRdata (regRdata),
    .memRdata (memRdata),
    .lastByte (lastByte),
    .regAddr  (regAddr),
    .memAddr  (memAddr),
    .dataOut  (dataOut),
    .ptrOut   (finPtr),
    .cntOut   (finCnt)
  );

  assign memWdata = dataOut;
  assign regWdata = dataOut;
  assign finIdx   = memAddr;

  p_fin_zero_r9: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (finCnt == '0));
  p_addr_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memAck) |=> ($stable(memAddr) && $stable(memWdata)));

endmodule

// File: tb/rbx_engine_bench.sv
module rbx_engine_bench;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       start = 1'b0;
  logic       dirToMem = 1'b0;
  logic [7:0] startPtr = '0;
  logic [9:0] startIdx = '0;
  logic [7:0] startCnt = '0;
  logic       busy, done, memReq, memWe, regWe;
  logic [9:0] memAddr;
  logic [7:0] memWdata, regWdata, regRdata, finPtr, finCnt;
  logic [9:0] finIdx;
  logic [5:0] regAddr;
  logic       memAck = 1'b0;
  logic [7:0] memRdata = '0;

  int total = 0;
  int bad = 0;
  int memDelay = 1;
  int waitCnt = 0;

  logic [7:0] rf [64];
  logic [7:0] mem [1024];
  logic [7:0] erf [64];
  logic [7:0] emem [1024];

  // Monitors
  int   badR6 = 0, badR10 = 0, nWr = 0, nRd = 0;
  logic prevAck = 1'b0, prevReq = 1'b0, prevWe = 1'b0;
  logic [9:0] prevAddr = '0;

  always #5 clk = ~clk;

  rbx_engine u_rbx_engine (
    .clk(clk), .rstN(rstN), .start(start), .dirToMem(dirToMem),
    .startPtr(startPtr), .startIdx(startIdx), .startCnt(startCnt),
    .busy(busy), .done(done), .memReq(memReq), .memWe(memWe),
    .memAddr(memAddr), .memWdata(memWdata), .memAck(memAck),
    .memRdata(memRdata), .regAddr(regAddr), .regWe(regWe),
    .regWdata(regWdata), .regRdata(regRdata), .finPtr(finPtr),
    .finIdx(finIdx), .finCnt(finCnt)
  );

  assign regRdata = rf[regAddr];

  always @(posedge clk) begin
    if (rstN && regWe) rf[regAddr] <= regWdata;
  end

  always @(posedge clk) begin
    if (!rstN) begin
      memAck  <= 1'b0;
      waitCnt <= 0;
    end else if (memAck) begin
      memAck <= 1'b0;
    end else if (memReq) begin
      if (waitCnt + 1 >= memDelay) begin
        memAck  <= 1'b1;
        waitCnt <= 0;
        if (memWe) mem[memAddr] <= memWdata;
        else       memRdata <= mem[memAddr];
      end else begin
        waitCnt <= waitCnt + 1;
      end
    end
  end

  always @(negedge clk) begin
    if (rstN) begin
      if (regWe && (!prevAck || memReq)) badR6++;
      if (prevReq && !prevAck &&
          (!memReq || memAddr != prevAddr || memWe != prevWe)) badR10++;
      if (memReq && memAck) begin
        if (memWe) nWr++; else nRd++;
      end
      prevAck  = memAck;
      prevReq  = memReq;
      prevWe   = memWe;
      prevAddr = memAddr;
    end
  end

  initial begin
    #2_000_000;
    bad++;
    total++;
    $display("FAIL R7 watchdog expired actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  task automatic fill_arrays(input int seed);
    for (int i = 0; i < 64; i++) rf[i] = 8'((i * 37 + seed) ^ 8'h5A);
    for (int i = 0; i < 1024; i++) mem[i] = 8'(i * 13 + seed * 3 + 1);
    for (int i = 0; i < 64; i++) erf[i] = rf[i];
    for (int i = 0; i < 1024; i++) emem[i] = mem[i];
  endtask

  // Generic run: model, start, wait, compare
  task automatic run_xfer(input string tag, input bit dir, input logic [7:0] b,
                          input logic [9:0] idx, input logic [7:0] cnt,
                          input int d, input bit inject);
    logic [7:0] mb, mc;
    logic [9:0] mi;
    int n, busyCyc, guard, mism, firstA;
    mb = b; mi = idx; mc = cnt; n = 0;
    do begin
      if (dir) emem[mi] = erf[mb[6:1]];
      else     erf[mb[6:1]] = emem[mi];
      mi = {mi[9:8], 8'(mi[7:0] + 1)};
      mb = 8'(mb + 2);
      mc = 8'(mc - 1);
      n++;
    end while (mc != 0);

    memDelay = d;
    badR6 = 0; badR10 = 0; nWr = 0; nRd = 0;
    @(negedge clk);
    dirToMem = dir; startPtr = b; startIdx = idx; startCnt = cnt; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    busyCyc = 0; guard = 0;
    while (!done && guard < 5000) begin
      if (busy) busyCyc++;
      if (inject && busyCyc == 3) begin
        start = 1'b1; dirToMem = !dir; startPtr = 8'h55;
        startIdx = 10'h000; startCnt = 8'd1;
      end else begin
        start = 1'b0;
      end
      guard++;
      @(negedge clk);
    end
    start = 1'b0;
    chk(done == 1'b1, "R7", {tag, " done seen"}, done, 1);
    chk(busy == 1'b0, "R7", {tag, " busy low at done"}, busy, 0);
    chk(busyCyc == n * (d + 2), "R7", {tag, " busy cycles"}, busyCyc, n * (d + 2));
    chk(finCnt == 8'd0, "R9", {tag, " final count"}, finCnt, 0);
    chk(finPtr == mb, "R2", {tag, " final pointer"}, finPtr, mb);
    chk(finIdx == mi, "R3", {tag, " final index"}, finIdx, mi);
    chk((dir ? nWr : nRd) == n, "R4", {tag, " byte count"}, dir ? nWr : nRd, n);
    chk((dir ? nRd : nWr) == 0, "R5", {tag, " wrong-direction accesses"}, dir ? nRd : nWr, 0);
    chk(badR6 == 0, "R6", {tag, " store timing"}, badR6, 0);
    chk(badR10 == 0, "R10", {tag, " request hold"}, badR10, 0);
    @(negedge clk);
    chk(done == 1'b0, "R7", {tag, " done one cycle"}, done, 0);
    mism = 0; firstA = 0;
    for (int i = 0; i < 1024; i++) if (mem[i] !== emem[i]) begin
      if (mism == 0) firstA = i;
      mism++;
    end
    chk(mism == 0, "R5", {tag, " memory image"}, mem[firstA], emem[firstA]);
    mism = 0; firstA = 0;
    for (int i = 0; i < 64; i++) if (rf[i] !== erf[i]) begin
      if (mism == 0) firstA = i;
      mism++;
    end
    chk(mism == 0, "R2", {tag, " register RAM image"}, rf[firstA], erf[firstA]);
  endtask

  task automatic t_reset();
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    chk(busy == 0 && done == 0 && memReq == 0 && regWe == 0, "R1",
        "reset outputs", {busy, done, memReq, regWe}, 0);
    rstN = 1'b1;
    @(negedge clk);
    chk(busy == 0 && memReq == 0, "R1", "idle after reset", {busy, memReq}, 0);
  endtask

  task automatic t_to_mem_basic();
    fill_arrays(1);
    run_xfer("R5 to-mem basic", 1'b1, 8'h10, 10'h2F0, 8'd5, 1, 1'b0);
  endtask

  task automatic t_index_wrap();
    fill_arrays(2);
    run_xfer("R3 index wrap", 1'b1, 8'h20, 10'h1FE, 8'd4, 2, 1'b0);
  endtask

  task automatic t_ptr_wrap_odd();
    fill_arrays(3);
    run_xfer("R2 odd pointer wrap", 1'b0, 8'hFB, 10'h305, 8'd5, 1, 1'b0);
  endtask

  task automatic t_from_mem_basic();
    fill_arrays(4);
    run_xfer("R6 from-mem slow ack", 1'b0, 8'h00, 10'h040, 8'd7, 3, 1'b0);
  endtask

  task automatic t_count_zero();
    fill_arrays(5);
    run_xfer("R4 zero count", 1'b0, 8'h06, 10'h0C0, 8'd0, 1, 1'b0);
  endtask

  task automatic t_start_ignored();
    fill_arrays(6);
    run_xfer("R8 start while busy", 1'b1, 8'h30, 10'h380, 8'd6, 1, 1'b1);
    repeat (4) begin
      @(negedge clk);
      chk(busy == 0 && memReq == 0, "R8", "no run after ignored start",
          {busy, memReq}, 0);
    end
  endtask

  initial begin
    fill_arrays(0);
    t_reset();
    t_to_mem_basic();
    t_index_wrap();
    t_ptr_wrap_odd();
    t_from_mem_basic();
    t_count_zero();
    t_start_ignored();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule